// File: doc/BRIEF.md
# Per-Field Range Rule Classifier

The block sorts a multi-field header into one of several rules. Each rule is a box of ranges, one range per field. Each field of each rule owns a short ordered list of ternary entries. In a list, only the earliest matching entry counts. Every entry carries a tag that says whether it describes the inside of the range or a piece cut out of it.

A field hits only when its earliest matching entry is an inside entry. A rule hits when all of its fields hit. A rule-level priority encoder picks the lowest-numbered hitting rule and looks up that rule's action code. When no rule hits, the encoder returns a built-in default action instead.

Because fields are matched one by one and then ANDed, a range rule over d fields of W bits needs no more than d·W entries. Entries and actions are written through a simple configuration port, one rule at a time. The result of a lookup appears one clock after the valid strobe.

Top module: `range_classifier`

## Requirements
- R1: An entry matches a field key when its enable bit is 1 and the key equals the entry value on every bit where the care mask bit is 1. An entry whose enable bit is 0 never matches, whatever its mask.
- R2: Within one field list, only the lowest-index matching entry decides the field. If its complement tag is 0, the field hits. If the tag is 1, the field misses. If no entry matches, the field misses.
- R3: A rule hits only when every one of its fields hits. Field f of the header occupies bits [f*FIELD_W +: FIELD_W] of `in_hdr`.
- R4: When several rules hit, `out_rule` reports the lowest-index hitting rule, and `out_action` is that rule's action slot.
- R5: When no rule hits, `out_hit` is 0, `out_rule` is 0 and `out_action` equals the parameter DEFAULT_ACT (7 by default).
- R6: A lookup strobed by `in_valid` in one cycle shows its result, with `out_valid` high, after the next rising edge. `out_valid` is low after every edge at which `in_valid` was low, and the result outputs then hold their last values.
- R7: Writing the entries or the action of one rule leaves the results of every other rule unchanged.
- R8: After reset, all entries are disabled, all action slots are 0, and `out_valid`, `out_hit`, `out_rule` and `out_action` are 0.
- R9: With FIELD_W=4, rule 0 holds [1,14]×[5,14] in 3+4 entries and rule 1 holds [7,10]×[2,3] in 3+1 entries. The header (8,7) then hits rule 0 only.
- R10: Each action slot holds any ACT_W-bit code. Codes beyond two values are returned exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lookup strobe |
| in_hdr | input | NUM_FIELDS*FIELD_W | Header; field f in bits [f*FIELD_W +: FIELD_W] |
| cfg_ent_we | input | 1 | Entry write enable |
| cfg_rule | input | RIW | Rule selected for the entry write |
| cfg_field | input | FIW | Field selected for the entry write |
| cfg_idx | input | EIW | Entry position within the list |
| cfg_value | input | FIELD_W | Entry value |
| cfg_care | input | FIELD_W | Care mask (1 = compare this bit) |
| cfg_compl | input | 1 | Complement tag (1 = entry lies outside the range) |
| cfg_on | input | 1 | Entry enable |
| cfg_act_we | input | 1 | Action slot write enable |
| cfg_act_rule | input | RIW | Rule whose action slot is written |
| cfg_act_code | input | ACT_W | Action code to store |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_hit | output | 1 | Some rule matched |
| out_rule | output | RIW | Lowest matching rule index |
| out_action | output | ACT_W | Action of that rule, or the default action |

## Verification
The bench aims at four corner cases.

- **Complement entries that shadow a later wildcard.** Keys 0 and 15 fall in the cut-out corners of [1,14]. A design that ignored the tag, or took the last match instead of the first, would report a hit there.
- **Headers where only one field of a rule fits.** Headers (7,3) and (0,7) catch an OR in place of the AND, and a rule-1 match leaking into rule 0.
- **An always-matching catch-all rule at the highest index.** It exposes a priority encoder that favours high indices. A disabled all-don't-care entry catches an enable bit that is not honoured.
- **Rewrites of one rule between identical lookups.** A decoder that strays into a neighbouring rule's entries or action slot would change the neighbour's result.

// File: rtl/rc_pkg.sv
package rc_pkg;

  // Ternary compare of one entry against a key; widths up to 32 bits.
  function automatic logic tern_hit(input logic on, input logic [31:0] key,
                                    input logic [31:0] val, input logic [31:0] care);
    return on && (((key ^ val) & care) == 32'd0);
  endfunction

  // Index width for a count of items (at least one bit).
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rc_field_list.sv
module rc_field_list #(
  parameter int W       = 4,
  parameter int ENTRIES = 4,
  parameter int EIW     = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [EIW-1:0] wr_idx,
  input  logic [W-1:0]   wr_val,
  input  logic [W-1:0]   wr_care,
  input  logic           wr_compl,
  input  logic           wr_on,
  input  logic [W-1:0]   key,
  output logic           field_hit
);

  logic [W-1:0]       val_q  [ENTRIES];
  logic [W-1:0]       care_q [ENTRIES];
  logic [ENTRIES-1:0] compl_q;
  logic [ENTRIES-1:0] on_q;

  // named internal events
  logic [ENTRIES-1:0] match_line;
  logic [ENTRIES-1:0] first_line;
  logic [ENTRIES-1:0] gated_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q    <= '0;
      compl_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        val_q[e]  <= '0;
        care_q[e] <= '0;
      end
    end else if (wr_en) begin
      val_q[wr_idx]   <= wr_val;
      care_q[wr_idx]  <= wr_care;
      compl_q[wr_idx] <= wr_compl;
      on_q[wr_idx]    <= wr_on;
    end
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_line
      assign match_line[e] = rc_pkg::tern_hit(on_q[e], 32'(key), 32'(val_q[e]),
                                              32'(care_q[e]));
    end
  endgenerate

  // first-match chain: a line passes only if no earlier line matched
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      first_line[e] = match_line[e] & ~seen;
      seen          = seen | match_line[e];
    end
  end

  // complement gating: outside-range entries zero their line
  assign gated_line = first_line & ~compl_q;
  assign field_hit  = |gated_line;

  assert_hit_needs_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    field_hit |-> (|match_line));

  assert_first_is_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_line) |-> $onehot(first_line));

  assert_storage_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(on_q) && $stable(compl_q)));

endmodule

// File: rtl/rc_prio_enc.sv
module rc_prio_enc #(
  parameter int                 NUM_RULES   = 3,
  parameter int                 RIW         = 2,
  parameter int                 ACT_W       = 3,
  parameter logic [ACT_W-1:0]   DEFAULT_ACT = '1
) (
  input  logic [NUM_RULES-1:0]       rule_hit,
  input  logic [NUM_RULES*ACT_W-1:0] act_tab,
  output logic                       any_hit,
  output logic [RIW-1:0]             win_idx,
  output logic [ACT_W-1:0]           win_act
);

  // scan from the top down so the lowest hitting index wins
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    win_act = DEFAULT_ACT;
    for (int r = NUM_RULES - 1; r >= 0; r--) begin
      if (rule_hit[r]) begin
        any_hit = 1'b1;
        win_idx = RIW'(r);
        win_act = act_tab[r*ACT_W +: ACT_W];
      end
    end
  end

endmodule

// File: rtl/range_classifier.sv
module range_classifier #(
  parameter int               NUM_RULES   = 3,
  parameter int               NUM_FIELDS  = 2,
  parameter int               FIELD_W     = 4,
  parameter int               ENTRIES     = FIELD_W,
  parameter int               ACT_W       = 3,
  parameter logic [ACT_W-1:0] DEFAULT_ACT = 3'd7,
  localparam int              RIW         = rc_pkg::idx_w(NUM_RULES),
  localparam int              FIW         = rc_pkg::idx_w(NUM_FIELDS),
  localparam int              EIW         = rc_pkg::idx_w(ENTRIES),
  localparam int              HDR_W       = NUM_FIELDS * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [HDR_W-1:0]   in_hdr,
  input  logic               cfg_ent_we,
  input  logic [RIW-1:0]     cfg_rule,
  input  logic [FIW-1:0]     cfg_field,
  input  logic [EIW-1:0]     cfg_idx,
  input  logic [FIELD_W-1:0] cfg_value,
  input  logic [FIELD_W-1:0] cfg_care,
  input  logic               cfg_compl,
  input  logic               cfg_on,
  input  logic               cfg_act_we,
  input  logic [RIW-1:0]     cfg_act_rule,
  input  logic [ACT_W-1:0]   cfg_act_code,
  output logic               out_valid,
  output logic               out_hit,
  output logic [RIW-1:0]     out_rule,
  output logic [ACT_W-1:0]   out_action
);

  logic [NUM_FIELDS-1:0]      fld_hit [NUM_RULES];
  logic [NUM_RULES-1:0]       rule_hit;
  logic [NUM_RULES*ACT_W-1:0] act_tab;
  logic                       any_hit;
  logic [RIW-1:0]             win_idx;
  logic [ACT_W-1:0]           win_act;

  generate
    for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
      for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        logic sel;
        assign sel = cfg_ent_we && (cfg_rule == RIW'(r)) && (cfg_field == FIW'(f));
        rc_field_list #(.W(FIELD_W), .ENTRIES(ENTRIES), .EIW(EIW)) u_list (
          .clk       (clk),
          .rst_n     (rst_n),
          .wr_en     (sel),
          .wr_idx    (cfg_idx),
          .wr_val    (cfg_value),
          .wr_care   (cfg_care),
          .wr_compl  (cfg_compl),
          .wr_on     (cfg_on),
          .key       (in_hdr[f*FIELD_W +: FIELD_W]),
          .field_hit (fld_hit[r][f])
        );
      end
      assign rule_hit[r] = &fld_hit[r];

      // action slot of this rule
      always_ff @(posedge clk) begin
        if (!rst_n)
          act_tab[r*ACT_W +: ACT_W] <= '0;
        else if (cfg_act_we && (cfg_act_rule == RIW'(r)))
          act_tab[r*ACT_W +: ACT_W] <= cfg_act_code;
      end
    end
  endgenerate

  rc_prio_enc #(.NUM_RULES(NUM_RULES), .RIW(RIW), .ACT_W(ACT_W),
                .DEFAULT_ACT(DEFAULT_ACT)) u_prio (
    .rule_hit (rule_hit),
    .act_tab  (act_tab),
    .any_hit  (any_hit),
    .win_idx  (win_idx),
    .win_act  (win_act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_rule   <= '0;
      out_action <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit    <= any_hit;
        out_rule   <= win_idx;
        out_action <= win_act;
      end
    end
  end

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_action) && $stable(out_rule)));

  assert_default_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_action == DEFAULT_ACT && out_rule == '0));

  assert_hit_is_any_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_hit == $past(|rule_hit)));

  assert_lowest_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|rule_hit)) |=>
      (((($past(rule_hit) >> out_rule) & NUM_RULES'(1)) != '0) &&
       (($past(rule_hit) & ((NUM_RULES'(1) << out_rule) - NUM_RULES'(1))) == '0)));

endmodule

// File: tb/test_range_classifier.sv
`timescale 1ns/1ps
module test_range_classifier;

  localparam int NR = 3, NF = 2, W = 4, NE = 4, AW = 3;
  localparam logic [AW-1:0] DEF = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [NF*W-1:0] in_hdr = '0;
  logic cfg_ent_we = 1'b0, cfg_compl = 1'b0, cfg_on = 1'b0, cfg_act_we = 1'b0;
  logic [1:0] cfg_rule = '0, cfg_act_rule = '0;
  logic [0:0] cfg_field = '0;
  logic [1:0] cfg_idx = '0;
  logic [W-1:0] cfg_value = '0, cfg_care = '0;
  logic [AW-1:0] cfg_act_code = '0;
  logic out_valid, out_hit;
  logic [1:0] out_rule;
  logic [AW-1:0] out_action;

  always #4 clk = ~clk;

  range_classifier i_range_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr(in_hdr),
    .cfg_ent_we(cfg_ent_we), .cfg_rule(cfg_rule), .cfg_field(cfg_field),
    .cfg_idx(cfg_idx), .cfg_value(cfg_value), .cfg_care(cfg_care),
    .cfg_compl(cfg_compl), .cfg_on(cfg_on), .cfg_act_we(cfg_act_we),
    .cfg_act_rule(cfg_act_rule), .cfg_act_code(cfg_act_code),
    .out_valid(out_valid), .out_hit(out_hit), .out_rule(out_rule),
    .out_action(out_action)
  );

  // bench-side model of the configuration
  logic [W-1:0] m_val [NR][NF][NE];
  logic [W-1:0] m_care[NR][NF][NE];
  logic         m_cmp [NR][NF][NE];
  logic         m_on  [NR][NF][NE];
  logic [AW-1:0] m_act[NR];

  typedef struct {
    logic          hit;
    logic [1:0]    rule;
    logic [AW-1:0] act;
    string         tag;
  } exp_t;

  exp_t sb[$];
  exp_t last_exp;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  function automatic bit field_in(int r, int f, logic [W-1:0] k);
    for (int e = 0; e < NE; e++)
      if (m_on[r][f][e] && ((k & m_care[r][f][e]) == (m_val[r][f][e] & m_care[r][f][e])))
        return !m_cmp[r][f][e];
    return 1'b0;
  endfunction

  function automatic exp_t predict(logic [W-1:0] k0, logic [W-1:0] k1, string tag);
    exp_t x;
    x.hit = 1'b0; x.rule = '0; x.act = DEF; x.tag = tag;
    for (int r = 0; r < NR; r++)
      if (!x.hit && field_in(r, 0, k0) && field_in(r, 1, k1)) begin
        x.hit = 1'b1; x.rule = 2'(r); x.act = m_act[r];
      end
    return x;
  endfunction

  task automatic check(string tag, bit ok, string what, int act_v, int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
    end
  endtask

  task automatic wr_ent(int r, int f, int e, logic [W-1:0] v, logic [W-1:0] c,
                        logic cm, logic on);
    @(negedge clk);
    cfg_ent_we = 1'b1; cfg_rule = 2'(r); cfg_field = 1'(f); cfg_idx = 2'(e);
    cfg_value = v; cfg_care = c; cfg_compl = cm; cfg_on = on;
    m_val[r][f][e] = v; m_care[r][f][e] = c; m_cmp[r][f][e] = cm; m_on[r][f][e] = on;
    @(negedge clk);
    cfg_ent_we = 1'b0;
  endtask

  task automatic wr_act(int r, logic [AW-1:0] a);
    @(negedge clk);
    cfg_act_we = 1'b1; cfg_act_rule = 2'(r); cfg_act_code = a;
    m_act[r] = a;
    @(negedge clk);
    cfg_act_we = 1'b0;
  endtask

  // driver: one-cycle strobe, expected item pushed to the scoreboard
  task automatic lookup(logic [W-1:0] k0, logic [W-1:0] k1, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_hdr = {k1, k0};
    sb.push_back(predict(k0, k1, tag));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R6: no strobe -> out_valid low, results held
  task automatic idle_check();
    @(negedge clk);
    check("R6", out_valid == 1'b0, "out_valid idle", int'(out_valid), 0);
    check("R6", out_action == last_exp.act, "held action", int'(out_action), int'(last_exp.act));
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check("R6", 1'b0, "unexpected out_valid", 1, 0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        last_exp = x;
        check(x.tag, out_hit == x.hit, "hit", int'(out_hit), int'(x.hit));
        check(x.tag, out_rule == x.rule, "rule", int'(out_rule), int'(x.rule));
        check(x.tag, out_action == x.act, "action", int'(out_action), int'(x.act));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < NR; r++) begin
      m_act[r] = '0;
      for (int f = 0; f < NF; f++)
        for (int e = 0; e < NE; e++) begin
          m_val[r][f][e] = '0; m_care[r][f][e] = '0;
          m_cmp[r][f][e] = 1'b0; m_on[r][f][e] = 1'b0;
        end
    end
    last_exp.hit = 1'b0; last_exp.rule = '0; last_exp.act = '0; last_exp.tag = "R8";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state at the ports
    check("R8", out_valid == 1'b0, "out_valid", int'(out_valid), 0);
    check("R8", out_hit == 1'b0, "out_hit", int'(out_hit), 0);
    check("R8", out_action == '0, "out_action", int'(out_action), 0);
    lookup(4'd8, 4'd7, "R8_empty_R5");
    idle_check();

    // rule 0: [1,14] x [5,14]
    wr_ent(0, 0, 0, 4'b0000, 4'b1111, 1'b1, 1'b1);
    wr_ent(0, 0, 1, 4'b1111, 4'b1111, 1'b1, 1'b1);
    wr_ent(0, 0, 2, 4'b0000, 4'b0000, 1'b0, 1'b1);
    wr_ent(0, 1, 0, 4'b1111, 4'b1111, 1'b1, 1'b1);
    wr_ent(0, 1, 1, 4'b0101, 4'b1111, 1'b0, 1'b1);
    wr_ent(0, 1, 2, 4'b0110, 4'b1110, 1'b0, 1'b1);
    wr_ent(0, 1, 3, 4'b1000, 4'b1000, 1'b0, 1'b1);
    // rule 1: [7,10] x [2,3]
    wr_ent(1, 0, 0, 4'b0111, 4'b1111, 1'b0, 1'b1);
    wr_ent(1, 0, 1, 4'b1000, 4'b1110, 1'b0, 1'b1);
    wr_ent(1, 0, 2, 4'b1010, 4'b1111, 1'b0, 1'b1);
    wr_ent(1, 1, 0, 4'b0010, 4'b1110, 1'b0, 1'b1);
    wr_act(0, 3'd2);
    wr_act(1, 3'd4);

    lookup(4'd8, 4'd7, "R9");
    lookup(4'd8, 4'd2, "R3_r1");
    lookup(4'd0, 4'd7, "R2_cut_lo");
    lookup(4'd15, 4'd15, "R2_cut_hi");
    lookup(4'd14, 4'd14, "R2_edge");
    lookup(4'd1, 4'd5, "R2_edge_lo");
    lookup(4'd7, 4'd3, "R3_one_field");
    lookup(4'd11, 4'd2, "R1_exact");
    idle_check();

    // rule 2: catch-all, field 0 entry disabled first
    wr_ent(2, 0, 0, 4'b0000, 4'b0000, 1'b0, 1'b0);
    wr_ent(2, 1, 0, 4'b0000, 4'b0000, 1'b0, 1'b1);
    wr_act(2, 3'd5);
    lookup(4'd0, 4'd0, "R1_disabled");
    wr_ent(2, 0, 0, 4'b0000, 4'b0000, 1'b0, 1'b1);
    lookup(4'd0, 4'd0, "R4_catchall");
    lookup(4'd8, 4'd7, "R4_prio");
    lookup(4'd8, 4'd2, "R4_prio_r1");
    wr_act(2, 3'd6);
    lookup(4'd15, 4'd0, "R10_code");

    // R7: rewrite rule 0 and its action; others unchanged
    wr_ent(0, 1, 3, 4'b1000, 4'b1000, 1'b0, 1'b0);
    wr_act(0, 3'd1);
    lookup(4'd8, 4'd2, "R7_r1_kept");
    lookup(4'd7, 4'd3, "R7_r1_kept2");
    lookup(4'd14, 4'd14, "R7_r0_changed");
    lookup(4'd8, 4'd7, "R7_r0_act");

    // R6: back-to-back strobes
    @(negedge clk);
    in_valid = 1'b1; in_hdr = {4'd7, 4'd8};
    sb.push_back(predict(4'd8, 4'd7, "R6_b2b_a"));
    @(negedge clk);
    in_hdr = {4'd2, 4'd9};
    sb.push_back(predict(4'd9, 4'd2, "R6_b2b_b"));
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    idle_check();

    repeat (3) @(negedge clk);
    check("R6", sb.size() == 0, "pending results", sb.size(), 0);
    finish_run();
  end

endmodule